// File: doc/BRIEF.md
# Boxcar Moving-Average Filter

This block smooths a stream of signed fixed-point samples by averaging the most recent `WINDOW` samples. It uses no multiplier. A circular buffer holds the last `WINDOW` samples. A running sum adds each new sample and removes the one that leaves the window, so the total is updated in one step. Because the window length is a power of two, the division becomes an arithmetic right shift of the sum.

A build-time mode parameter picks one of two outputs. The low-pass variant emits the window average. The high-pass variant emits the newest sample minus that average, clamped to the sample range. Input and output are valid/ready streams. A single output register decouples the two sides. Every accepted input produces exactly one output, and backpressure on the output stalls the input side without losing anything.

Top module: `boxcar_avg`

## Requirements
- R1: In low-pass mode the output for an accepted sample is the sum of that sample and the previous `WINDOW-1` accepted samples, shifted arithmetically right by log2(`WINDOW`), which rounds toward minus infinity. `WINDOW` must be a power of two, and any other value stops elaboration.
- R2: In high-pass mode the output is the accepted sample minus the value defined in R1, saturated to the range -2^(W-1) .. 2^(W-1)-1 rather than wrapped.
- R3: Each accepted input (`in_valid` and `in_ready` both high at a rising edge) makes `out_valid` high after that edge. A result that is consumed with no new input behind it clears `out_valid` after the edge.
- R4: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. An offered input is not taken and leaves no trace in later results.
- R6: After reset `out_valid` is low, `in_ready` is high, and the buffer and sum are zero. The first `WINDOW-1` outputs therefore average the received samples together with zeros.
- R7: A sample contributes to exactly `WINDOW` consecutive outputs and then drops out of the sum.
- R8: The running sum is log2(`WINDOW`) bits wider than a sample. A full window of the most negative or the most positive sample value averages back to that same value without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take the offered sample |
| in_data | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | SAMPLE_W | Signed filtered sample |

## Verification
The bench builds two copies with 8-bit samples and a 4-sample window, one in low-pass mode and one in high-pass mode. Both are fed the same stream. The narrow samples let a few inputs reach both saturation limits of the high-pass subtraction and the full-scale sums at either extreme. The short window makes the buffer wrap many times, so samples leaving the window can be observed. Random valid and ready patterns cover stalls, back-to-back transfers and negative sums that round down.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

    typedef enum logic {
        BOX_LOWPASS  = 1'b0,
        BOX_HIGHPASS = 1'b1
    } boxcar_mode_e;

endpackage

// File: rtl/boxcar_ring.sv
module boxcar_ring #(
    parameter int SAMPLE_W = 16,
    parameter int WINDOW   = 32,
    localparam int PTR_W   = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic signed [SAMPLE_W-1:0] new_sample,
    output logic signed [SAMPLE_W-1:0] old_sample
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic signed [SAMPLE_W-1:0] mem_q [WINDOW];

    // The slot about to be overwritten holds the sample that leaves the window.
    assign old_sample = mem_q[st_q.wptr];

    always_comb begin
        st_d = st_q;
        if (push) begin
            if (st_q.wptr == PTR_W'(WINDOW - 1)) begin
                st_d.wptr = '0;
            end else begin
                st_d.wptr = st_q.wptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < WINDOW; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
            if (push) begin
                mem_q[st_q.wptr] <= new_sample;
            end
        end
    end

    // R7: the write pointer advances by exactly one slot per accepted sample
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (st_q.wptr == ((WINDOW > 1) ? PTR_W'(($past(st_q.wptr) + 1) % WINDOW) : '0)));

    // R5: no accepted sample, no movement
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(st_q.wptr));

endmodule

// File: rtl/boxcar_accum.sv
module boxcar_accum #(
    parameter int SAMPLE_W = 16,
    parameter int WINDOW   = 32,
    localparam int SHIFT   = $clog2(WINDOW),
    localparam int ACC_W   = SAMPLE_W + SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic signed [SAMPLE_W-1:0] new_sample,
    input  logic signed [SAMPLE_W-1:0] old_sample,
    output logic signed [SAMPLE_W-1:0] avg_next
);

    typedef struct packed {
        logic signed [ACC_W-1:0] sum;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic signed [ACC_W-1:0] sum_upd;
    logic signed [ACC_W-1:0] sum_shr;

    always_comb begin
        sum_upd  = st_q.sum + ACC_W'(new_sample) - ACC_W'(old_sample);
        sum_shr  = sum_upd >>> SHIFT;
        avg_next = sum_shr[SAMPLE_W-1:0];
        st_d     = st_q;
        if (push) begin
            st_d.sum = sum_upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: the registered sum always stays within what WINDOW samples can add up to
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(st_q.sum) >= -(longint'(WINDOW) * (longint'(1) << (SAMPLE_W - 1)))) &&
        (longint'(st_q.sum) <=  (longint'(WINDOW) * ((longint'(1) << (SAMPLE_W - 1)) - 1))));

endmodule

// File: rtl/boxcar_post.sv
module boxcar_post
    import boxcar_pkg::*;
#(
    parameter int           SAMPLE_W = 16,
    parameter boxcar_mode_e MODE     = BOX_LOWPASS
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [SAMPLE_W-1:0] avg,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam logic signed [SAMPLE_W:0] MAX_V = (SAMPLE_W + 1)'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [SAMPLE_W:0] MIN_V = -(SAMPLE_W + 1)'(1 << (SAMPLE_W - 1));

    generate
        if (MODE == BOX_HIGHPASS) begin : g_high
            logic signed [SAMPLE_W:0] diff;
            always_comb begin
                diff = (SAMPLE_W + 1)'(sample) - (SAMPLE_W + 1)'(avg);
                if (diff > MAX_V) begin
                    result = MAX_V[SAMPLE_W-1:0];
                end else if (diff < MIN_V) begin
                    result = MIN_V[SAMPLE_W-1:0];
                end else begin
                    result = diff[SAMPLE_W-1:0];
                end
            end
        end else begin : g_low
            logic unused_sample;
            assign unused_sample = ^sample;
            assign result = avg;
        end
    endgenerate

endmodule

// File: rtl/boxcar_avg.sv
module boxcar_avg
    import boxcar_pkg::*;
#(
    parameter int           SAMPLE_W = 16,
    parameter int           WINDOW   = 32,
    parameter boxcar_mode_e MODE     = BOX_LOWPASS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [SAMPLE_W-1:0] in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [SAMPLE_W-1:0] out_data
);

    generate
        if ((WINDOW < 1) || (WINDOW != (1 << $clog2(WINDOW)))) begin : g_bad_window
            $error("boxcar_avg: WINDOW must be a power of two");
        end
    endgenerate

    typedef struct packed {
        logic                       valid;
        logic signed [SAMPLE_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;
    logic in_fire;
    logic signed [SAMPLE_W-1:0] oldest;
    logic signed [SAMPLE_W-1:0] avg_next;
    logic signed [SAMPLE_W-1:0] post_data;

    assign in_ready  = !st_q.valid || out_ready;
    assign in_fire   = in_valid && in_ready;
    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

    boxcar_ring #(.SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (in_fire),
        .new_sample (in_data),
        .old_sample (oldest)
    );

    boxcar_accum #(.SAMPLE_W(SAMPLE_W), .WINDOW(WINDOW)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (in_fire),
        .new_sample (in_data),
        .old_sample (oldest),
        .avg_next   (avg_next)
    );

    boxcar_post #(.SAMPLE_W(SAMPLE_W), .MODE(MODE)) u_post (
        .sample (in_data),
        .avg    (avg_next),
        .result (post_data)
    );

    always_comb begin
        st_d = st_q;
        if (in_fire) begin
            st_d.valid = 1'b1;
            st_d.data  = post_data;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: an accepted sample always yields a pending result
    assert_fire_gives_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> out_valid);

    // R3: a consumed result with nothing behind it empties the register
    assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R5: a stalled result is held unchanged
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: when a result is stalled the input side is closed
    assert_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/boxcar_avg_tb.sv
`timescale 1ns/1ps
module boxcar_avg_tb;
    import boxcar_pkg::*;

    localparam int W     = 8;
    localparam int N     = 4;
    localparam int SHIFT = 2;
    localparam int VMAX  = 127;
    localparam int VMIN  = -128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic signed [W-1:0] in_data = '0;

    logic in_ready_lp, in_ready_hp, ov_lp, ov_hp;
    logic signed [W-1:0] od_lp, od_hp;

    boxcar_avg #(.SAMPLE_W(W), .WINDOW(N), .MODE(BOX_LOWPASS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_lp),
        .in_data(in_data), .out_valid(ov_lp), .out_ready(out_ready), .out_data(od_lp)
    );

    boxcar_avg #(.SAMPLE_W(W), .WINDOW(N), .MODE(BOX_HIGHPASS)) u_dut_hp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_hp),
        .in_data(in_data), .out_valid(ov_hp), .out_ready(out_ready), .out_data(od_hp)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int win[$];
    bit m_valid = 1'b0;
    int m_lp = 0;
    int m_hp = 0;
    string tag = "R6";
    bit timed_out = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: compare outputs left by the last edge, apply new inputs,
    // then advance the reference model across the coming edge.
    task automatic cycle(input bit v, input int d, input bit r);
        int s;
        @(negedge clk);
        chk("R3 out_valid low-pass", int'(ov_lp), int'(m_valid));
        chk("R3 out_valid high-pass", int'(ov_hp), int'(m_valid));
        if (m_valid) begin
            chk({"R1 ", tag, " low-pass data"}, int'(od_lp), m_lp);
            chk({"R2 ", tag, " high-pass data"}, int'(od_hp), m_hp);
        end
        in_valid  = v;
        in_data   = W'(d);
        out_ready = r;
        #1;
        chk("R4 in_ready low-pass", int'(in_ready_lp), int'(!m_valid || r));
        chk("R4 in_ready high-pass", int'(in_ready_hp), int'(!m_valid || r));
        if (v && (!m_valid || r)) begin
            win.push_back(d);
            void'(win.pop_front());
            s = 0;
            foreach (win[k]) s += win[k];
            m_lp = s >>> SHIFT;
            m_hp = d - m_lp;
            if (m_hp > VMAX) m_hp = VMAX;
            if (m_hp < VMIN) m_hp = VMIN;
            m_valid = 1'b1;
        end else if (r) begin
            m_valid = 1'b0;
        end
    endtask

    task automatic run();
        // R6: reset state
        repeat (3) @(negedge clk);
        chk("R6 out_valid in reset", int'(ov_lp), 0);
        chk("R6 in_ready in reset", int'(in_ready_hp), 1);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) win.push_back(0);

        // R6: ramp from the zeroed window
        tag = "R6";
        cycle(1, 8, 1); cycle(1, 16, 1); cycle(1, 24, 1); cycle(1, -9, 1);

        // R8: full windows at both extremes
        tag = "R8";
        for (int i = 0; i < N + 2; i++) cycle(1, VMIN, 1);
        for (int i = 0; i < N + 2; i++) cycle(1, VMAX, 1);

        // R2: drive both saturation limits of the high-pass difference
        tag = "R2";
        cycle(1, VMIN, 1);
        for (int i = 0; i < N - 1; i++) cycle(1, VMIN, 1);
        cycle(1, VMAX, 1);

        // R7: single impulse must leave the sum after N samples
        tag = "R7";
        cycle(1, 100, 1);
        for (int i = 0; i < N + 3; i++) cycle(1, 0, 1);

        // R5: stalled output, changing offers must not be taken
        tag = "R5";
        cycle(1, 40, 0);
        for (int i = 0; i < 4; i++) cycle(1, -60 + 17 * i, 0);
        cycle(0, 0, 1);
        cycle(1, 12, 1);
        cycle(0, 0, 1);

        // R1: random traffic with random backpressure
        tag = "R1";
        for (int i = 0; i < 400; i++) begin
            cycle(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)) - 128,
                  bit'($urandom_range(0, 2) != 0));
        end
        cycle(0, 0, 1);
        cycle(0, 0, 1);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule